// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Unit

This block keeps the IEEE 754 exception part of a 64-bit floating-point status register. An arithmetic pipe signals each finished operation with a one-cycle strobe. With the strobe it gives the operation kind (add, multiply, divide or square root), a class tag for each operand and three raw indications from the rounding stage: overflow, tiny result and inexact. The block turns these into a five-bit current-exception field. It folds that field into a sticky accrued field. When any raised exception has its enable bit set, it raises a trap request.

The unit decides invalid and divide-by-zero itself, from the operand tags. Overflow, underflow and inexact come from the raw indications and follow the combining rules of the standard. Enabling the overflow or underflow trap changes what the current field reports. A trapping operation leaves the accrued field as it was, so a handler sees the state from before the faulting operation. Software can load the whole register through a write port. That write wins over an operation that finishes in the same cycle.

Top module: `fp_exc_status`

## Requirements
- R1: After reset the whole register reads zero and trapReq is low. The current field sits at bits 4:0, the accrued field at bits 9:5 and the trap-enable field at bits 27:23. Inside each field, bit 4 is invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero and bit 0 inexact. An operand tag is four bits: bit 3 zero, bit 2 infinity, bit 1 signaling NaN, bit 0 negative.
- R2: Invalid is raised by any of these: a NaN operand to add, multiply or divide (operand a only for square root); infinities of opposite sign added; zero times infinity in either order; 0/0; infinity divided by infinity of any signs; the square root of a negative value that is not zero.
- R3: A divide whose divisor is zero and whose dividend is finite and nonzero raises divide-by-zero and not invalid. Infinity divided by zero raises nothing.
- R4: With the overflow trap disabled, a raw overflow sets both overflow and inexact.
- R5: With the underflow trap disabled, underflow is set only for a tiny result that is also inexact, and then inexact is set too. A tiny exact result sets nothing. With the underflow trap enabled, any tiny result sets underflow.
- R6: With the overflow (or underflow) trap enabled, an operation raising that exception reports it alone in the current field, without inexact.
- R7: trapReq is high in the cycle after a completed operation exactly when the new current bits AND the trap enables held at the strobe are nonzero. Otherwise it is low.
- R8: On an operation without a trap, the accrued field becomes its old value ORed with the new current bits. On a trapping operation it is left unchanged.
- R9: Every completed operation overwrites the current field on the next clock edge. Without a strobe or a write, the register does not change.
- R10: A software write loads all 64 bits on the next edge and takes priority over an operation strobe in the same cycle.
- R11: When invalid or divide-by-zero is raised, the raw overflow, tiny and inexact indications are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opDone | input | 1 | One-cycle strobe for a completed operation |
| opClass | input | 2 | Operation kind: 0 add, 1 multiply, 2 divide, 3 square root |
| aTag | input | 4 | Class tag of operand a (R1 encoding) |
| bTag | input | 4 | Class tag of operand b (R1 encoding) |
| rawOvf | input | 1 | Rounded result overflowed |
| rawTiny | input | 1 | Result is tiny |
| rawInexact | input | 1 | Result was rounded |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 64 | Software write value |
| statusReg | output | 64 | Status register contents |
| trapReq | output | 1 | Trap request for the last operation |

## Verification
The bench builds the unit with its default parameters: a 64-bit register with the fields at bits 0, 5 and 23. It can therefore give exact bit positions for every field. Random software writes load arbitrary trap-enable patterns. Each enable pattern is then crossed with random operand tags and raw flags. This reaches the interaction between the enable-dependent underflow and inexact rules and the accrued hold. Directed cases cover every invalid pattern, divide-by-zero next to 0/0 and inf/0, and a write that collides with a strobe.

// File: rtl/fp_exc_pkg.sv
package fp_exc_pkg;

  localparam int EXC_W = 5;
  localparam int NV_B  = 4;
  localparam int OF_B  = 3;
  localparam int UF_B  = 2;
  localparam int DZ_B  = 1;
  localparam int NX_B  = 0;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MUL  = 2'd1,
    OP_DIV  = 2'd2,
    OP_SQRT = 2'd3
  } opKind_e;

  typedef struct packed {
    logic zero;
    logic inf;
    logic nan;
    logic neg;
  } opTag_t;

  // strobes from control to the register datapath
  typedef struct packed {
    logic swLoad;
    logic opLoad;
    logic accHold;
    logic trapFire;
  } updStb_t;

endpackage

// File: rtl/fp_exc_detect.sv
module fp_exc_detect
  import fp_exc_pkg::*;
(
  input  logic [1:0]       opClass,
  input  logic [3:0]       aTag,
  input  logic [3:0]       bTag,
  input  logic             rawOvf,
  input  logic             rawTiny,
  input  logic             rawInexact,
  input  logic [EXC_W-1:0] trapEn,
  output logic [EXC_W-1:0] excVec
);

  opTag_t  aT, bT;
  opKind_e kind;
  logic nanIn, nvSpecial, nv, dz, special;
  logic ofBit, ufBit, nxRaw, nxBit;

  always_comb begin
    aT   = opTag_t'(aTag);
    bT   = opTag_t'(bTag);
    kind = opKind_e'(opClass);
    nanIn = aT.nan | ((kind != OP_SQRT) & bT.nan);
    unique case (kind)
      OP_ADD:  nvSpecial = aT.inf & bT.inf & (aT.neg ^ bT.neg);
      OP_MUL:  nvSpecial = (aT.zero & bT.inf) | (aT.inf & bT.zero);
      OP_DIV:  nvSpecial = (aT.zero & bT.zero) | (aT.inf & bT.inf);
      default: nvSpecial = aT.neg & ~aT.zero;
    endcase
    nv = nanIn | nvSpecial;
    dz = ~nv & (kind == OP_DIV) & bT.zero & ~aT.zero & ~aT.inf;
    special = nv | dz;
    ofBit = ~special & rawOvf;
    ufBit = ~special & rawTiny & (rawInexact | trapEn[UF_B]);
    nxRaw = ~special & (rawInexact | rawOvf);
    nxBit = nxRaw & ~(ofBit & trapEn[OF_B]) & ~(ufBit & trapEn[UF_B]);
    excVec = '0;
    excVec[NV_B] = nv;
    excVec[OF_B] = ofBit;
    excVec[UF_B] = ufBit;
    excVec[DZ_B] = dz;
    excVec[NX_B] = nxBit;
  end

endmodule

// File: rtl/fp_exc_ctrl.sv
module fp_exc_ctrl
  import fp_exc_pkg::*;
(
  input  logic             opDone,
  input  logic             swWrEn,
  input  logic [EXC_W-1:0] excVec,
  input  logic [EXC_W-1:0] trapEn,
  output updStb_t          stb
);

  logic anyTrap;

  always_comb begin
    anyTrap      = |(excVec & trapEn);
    stb.swLoad   = swWrEn;
    stb.opLoad   = opDone & ~swWrEn;
    stb.trapFire = opDone & anyTrap;
    stb.accHold  = anyTrap;
  end

endmodule

// File: rtl/fp_exc_regs.sv
module fp_exc_regs
  import fp_exc_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int CUR_LSB = 0,
  parameter int ACC_LSB = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  updStb_t          stb,
  input  logic [REG_W-1:0] swWrData,
  input  logic [EXC_W-1:0] excVec,
  output logic [REG_W-1:0] statusReg,
  output logic             trapReq
);

  logic [EXC_W-1:0] accNow;
  assign accNow = statusReg[ACC_LSB +: EXC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      trapReq   <= 1'b0;
    end else begin
      trapReq <= stb.trapFire;
      if (stb.swLoad) begin
        statusReg <= swWrData;
      end else if (stb.opLoad) begin
        statusReg[CUR_LSB +: EXC_W] <= excVec;
        if (!stb.accHold) statusReg[ACC_LSB +: EXC_W] <= accNow | excVec;
      end
    end
  end

endmodule

// File: rtl/fp_exc_status.sv
module fp_exc_status
  import fp_exc_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int CUR_LSB = 0,
  parameter int ACC_LSB = 5,
  parameter int TEN_LSB = 23
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opDone,
  input  logic [1:0]       opClass,
  input  logic [3:0]       aTag,
  input  logic [3:0]       bTag,
  input  logic             rawOvf,
  input  logic             rawTiny,
  input  logic             rawInexact,
  input  logic             swWrEn,
  input  logic [REG_W-1:0] swWrData,
  output logic [REG_W-1:0] statusReg,
  output logic             trapReq
);

  logic [EXC_W-1:0] trapEn;
  logic [EXC_W-1:0] excVec;
  updStb_t          stb;

  assign trapEn = statusReg[TEN_LSB +: EXC_W];

  fp_exc_detect uDetect (
    .opClass(opClass), .aTag(aTag), .bTag(bTag),
    .rawOvf(rawOvf), .rawTiny(rawTiny), .rawInexact(rawInexact),
    .trapEn(trapEn), .excVec(excVec)
  );

  fp_exc_ctrl uCtrl (
    .opDone(opDone), .swWrEn(swWrEn), .excVec(excVec),
    .trapEn(trapEn), .stb(stb)
  );

  fp_exc_regs #(.REG_W(REG_W), .CUR_LSB(CUR_LSB), .ACC_LSB(ACC_LSB)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .swWrData(swWrData),
    .excVec(excVec), .statusReg(statusReg), .trapReq(trapReq)
  );

endmodule

// File: rtl/fp_exc_checker.sv
module fp_exc_checker
  import fp_exc_pkg::*;
#(
  parameter int REG_W   = 64,
  parameter int CUR_LSB = 0,
  parameter int ACC_LSB = 5,
  parameter int TEN_LSB = 23
) (
  input logic             clk,
  input logic             rstN,
  input logic             opDone,
  input logic             swWrEn,
  input logic [REG_W-1:0] swWrData,
  input logic [REG_W-1:0] statusReg,
  input logic             trapReq
);

  logic [EXC_W-1:0] cur, acc, ten;
  assign cur = statusReg[CUR_LSB +: EXC_W];
  assign acc = statusReg[ACC_LSB +: EXC_W];
  assign ten = statusReg[TEN_LSB +: EXC_W];

  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    swWrEn |=> statusReg == $past(swWrData)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!opDone && !swWrEn) |=> $stable(statusReg)); // R9
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !swWrEn) |=> trapReq == (|(cur & ten))); // R7
  AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(opDone)); // R7
  AST_ACC_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !swWrEn) |=>
      (trapReq ? (acc == $past(acc)) : (acc == ($past(acc) | cur)))); // R8
  AST_NO_NX_ON_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !swWrEn) |=>
      !(cur[NX_B] && ((cur[OF_B] && ten[OF_B]) || (cur[UF_B] && ten[UF_B])))); // R6
  AST_DZ_NOT_NV: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && !swWrEn) |=> !(cur[NV_B] && cur[DZ_B])); // R3

endmodule

bind fp_exc_status fp_exc_checker #(
  .REG_W(REG_W), .CUR_LSB(CUR_LSB), .ACC_LSB(ACC_LSB), .TEN_LSB(TEN_LSB)
) uChecker (
  .clk(clk), .rstN(rstN), .opDone(opDone), .swWrEn(swWrEn),
  .swWrData(swWrData), .statusReg(statusReg), .trapReq(trapReq)
);

// File: tb/fp_exc_status_test.sv
`timescale 1ns/1ps
module fp_exc_status_test;

  localparam logic [1:0] ADD = 2'd0, MUL = 2'd1, DIV = 2'd2, SQR = 2'd3;
  localparam logic [3:0] TN = 4'b0000, TZ = 4'b1000, TI = 4'b0100,
                         TNI = 4'b0101, TNAN = 4'b0010, TNEG = 4'b0001,
                         TNZ = 4'b1001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opDone = 1'b0;
  logic [1:0] opClass = '0;
  logic [3:0] aTag = '0, bTag = '0;
  logic rawOvf = 1'b0, rawTiny = 1'b0, rawInexact = 1'b0;
  logic swWrEn = 1'b0;
  logic [63:0] swWrData = '0;
  logic [63:0] statusReg;
  logic trapReq;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [63:0] mdlReg = '0;
  logic mdlTrap = 1'b0;

  always #10 clk = ~clk;

  fp_exc_status uut (
    .clk(clk), .rstN(rstN), .opDone(opDone), .opClass(opClass),
    .aTag(aTag), .bTag(bTag), .rawOvf(rawOvf), .rawTiny(rawTiny),
    .rawInexact(rawInexact), .swWrEn(swWrEn), .swWrData(swWrData),
    .statusReg(statusReg), .trapReq(trapReq)
  );

  // expected current bits: {NV, OF, UF, DZ, NX}
  function automatic logic [4:0] mdlExc(input logic [1:0] c, input logic [3:0] a,
      input logic [3:0] b, input logic ov, input logic ti, input logic nx,
      input logic [4:0] ten);
    logic nv, dz, of, uf, x;
    nv = a[1] || (c != SQR && b[1]);
    if (c == ADD && a[2] && b[2] && (a[0] != b[0])) nv = 1'b1;
    if (c == MUL && ((a[3] && b[2]) || (a[2] && b[3]))) nv = 1'b1;
    if (c == DIV && ((a[3] && b[3]) || (a[2] && b[2]))) nv = 1'b1;
    if (c == SQR && a[0] && !a[3]) nv = 1'b1;
    dz = !nv && c == DIV && b[3] && !a[3] && !a[2];
    if (nv || dz) return {nv, 2'b00, dz, 1'b0};
    of = ov;
    uf = ti && (nx || ten[2]);
    x = nx || ov;
    if (of && ten[3]) x = 1'b0;
    if (uf && ten[2]) x = 1'b0;
    return {1'b0, of, uf, 1'b0, x};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic op, input logic [1:0] c, input logic [3:0] a,
      input logic [3:0] b, input logic ov, input logic ti, input logic nx,
      input logic wr, input logic [63:0] wd, input string req);
    logic [4:0] e, ten;
    opDone = op; opClass = c; aTag = a; bTag = b;
    rawOvf = ov; rawTiny = ti; rawInexact = nx; swWrEn = wr; swWrData = wd;
    ten = mdlReg[27:23];
    e = mdlExc(c, a, b, ov, ti, nx, ten);
    mdlTrap = op && |(e & ten);
    if (wr) mdlReg = wd;
    else if (op) begin
      mdlReg[4:0] = e;
      if (!(|(e & ten))) mdlReg[9:5] = mdlReg[9:5] | e;
    end
    @(posedge clk);
    @(negedge clk);
    opDone = 1'b0; swWrEn = 1'b0;
    check(req, statusReg, mdlReg);
    check(req, {63'b0, trapReq}, {63'b0, mdlTrap});
  endtask

  task automatic op(input logic [1:0] c, input logic [3:0] a, input logic [3:0] b,
      input logic ov, input logic ti, input logic nx, input string req);
    step(1'b1, c, a, b, ov, ti, nx, 1'b0, 64'h0, req);
  endtask

  task automatic wr(input logic [63:0] d, input string req);
    step(1'b0, ADD, TN, TN, 1'b0, 1'b0, 1'b0, 1'b1, d, req);
  endtask

  function automatic logic [3:0] randTag();
    logic [3:0] t;
    case ($urandom % 4)
      0: t = TN;
      1: t = TZ;
      2: t = TI;
      default: t = TNAN;
    endcase
    t[0] = 1'($urandom % 2);
    return t;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 reset", statusReg, 64'h0);
    check("R1 reset trap", {63'b0, trapReq}, 64'h0);

    op(MUL, TN, TN, 1, 0, 1, "R4");
    check("R4 cur", {59'b0, statusReg[4:0]}, 64'h09);
    check("R8 acc", {59'b0, statusReg[9:5]}, 64'h09);
    op(DIV, TNEG, TN, 0, 1, 1, "R5");
    check("R5 cur", {59'b0, statusReg[4:0]}, 64'h05);
    op(MUL, TN, TN, 0, 1, 0, "R5 exact");
    check("R5 tiny exact", {59'b0, statusReg[4:0]}, 64'h00);
    check("R8 sticky", {59'b0, statusReg[9:5]}, 64'h0D);
    op(DIV, TN, TZ, 0, 0, 0, "R3");
    check("R3 dz", {59'b0, statusReg[4:0]}, 64'h02);
    op(DIV, TZ, TZ, 0, 0, 0, "R2 0/0");
    check("R2 0/0", {59'b0, statusReg[4:0]}, 64'h10);
    op(DIV, TI, TZ, 0, 0, 0, "R3 inf/0");
    check("R3 inf/0", {59'b0, statusReg[4:0]}, 64'h00);
    op(ADD, TI, TNI, 0, 0, 0, "R2 inf-inf");
    check("R2 inf-inf", {59'b0, statusReg[4:0]}, 64'h10);
    op(ADD, TI, TI, 0, 0, 0, "R2 inf+inf");
    check("R2 inf+inf", {59'b0, statusReg[4:0]}, 64'h00);
    op(MUL, TI, TZ, 0, 0, 0, "R2 inf*0");
    op(DIV, TNI, TI, 0, 0, 0, "R2 inf/inf");
    op(SQR, TNEG, TN, 0, 0, 0, "R2 sqrt neg");
    check("R2 sqrt neg", {59'b0, statusReg[4:0]}, 64'h10);
    op(SQR, TNZ, TNAN, 0, 0, 0, "R2 sqrt -0");
    check("R2 sqrt -0", {59'b0, statusReg[4:0]}, 64'h00);
    op(ADD, TN, TNAN, 0, 0, 1, "R2 nan");
    op(DIV, TN, TZ, 1, 0, 1, "R11");
    check("R11 dz only", {59'b0, statusReg[4:0]}, 64'h02);

    wr(64'h0000_0000_0400_0000, "R10 enable OF");
    check("R1 ten field", {59'b0, statusReg[27:23]}, 64'h08);
    op(MUL, TN, TN, 1, 0, 1, "R6 of trap");
    check("R6 of alone", {59'b0, statusReg[4:0]}, 64'h08);
    check("R7 trap", {63'b0, trapReq}, 64'h1);
    check("R8 hold", {59'b0, statusReg[9:5]}, 64'h00);
    wr(64'h0000_0000_0200_0000, "R10 enable UF");
    op(MUL, TN, TN, 0, 1, 0, "R5 uf trap exact");
    check("R5 uf trap", {59'b0, statusReg[4:0]}, 64'h04);
    check("R7 uf trap", {63'b0, trapReq}, 64'h1);
    op(ADD, TN, TN, 0, 0, 1, "R7 no trap");
    check("R7 nx untrapped", {63'b0, trapReq}, 64'h0);
    step(1'b1, DIV, TN, TZ, 0, 0, 0, 1'b1, 64'hDEAD_BEEF_0000_0155, "R10 collide");
    check("R10 collide", statusReg, 64'hDEAD_BEEF_0000_0155);
    for (int k = 0; k < 3; k++) step(1'b0, MUL, TN, TN, 1, 1, 1, 1'b0, 64'h0, "R9 idle");

    for (int k = 0; k < 600; k++) begin
      logic ov, ti;
      ov = 1'($urandom % 3 == 0);
      ti = !ov && ($urandom % 3 == 0);
      if ($urandom % 10 == 0)
        wr({$urandom, $urandom}, "R10 random write");
      else
        step(1'($urandom % 8 != 0), 2'($urandom % 4), randTag(), randTag(),
             ov, ti, 1'($urandom % 2), 1'($urandom % 20 == 0),
             {$urandom, $urandom}, "R9 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule